// File: doc/BRIEF.md
# SPI master byte shifter

This block is the master side of a synchronous serial link. A host reaches it through a small register port that has three addresses: control, status and data. Software first sets the enable and master bits and picks a clock rate. A write to the data address then starts a serial clock and moves one byte out on the data output, most significant bit first. The byte clocked in from the data input is captured during the same transfer. After the last bit the clock stops by itself, a completion flag is raised and, if enabled, an interrupt request follows. Software clears the flag by writing a one to it.

The transmit side has one buffer: the byte being sent sits in the shift register, and any data write that arrives while a transfer runs is dropped. The receive side has a second stage: each finished byte is copied into a read buffer. That buffer holds its value until the next transfer finishes, so software can read it while a new byte is already shifting. The block does not drive any select line. Software drives the peripheral select through an ordinary general-purpose output before and after each packet.

Timing is SPI mode 0. The clock idles low and the incoming bit is sampled on its rising edge. The outgoing bit changes only on a falling edge. The rate select offers four dividers of the system clock. The divider runs only while a transfer is in progress.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, SCK, MOSI and IRQ are low, and the control (address 0), status (address 1) and data (address 2) registers all read as zero.
- R2: A write to address 2 while control bit 0 (enable) and bit 1 (master) are both set produces exactly 8 rising SCK edges. SCK is high for 4·N cycles in total, where N is the selected divider, and SCK stays low whenever no transfer is active.
- R3: Control bits [4:3] select the divider N: 00 gives 4, 01 gives 16, 10 gives 64 and 11 gives 128. The first rising SCK edge comes N/2 cycles after the data write, and the rate is latched when the transfer starts.
- R4: MOSI carries the written byte MSB first. The first bit is present from the start, and the line changes only on falling SCK edges, so it is stable at every rising edge.
- R5: MISO is sampled on each rising SCK edge. The last falling edge occurs 8·N cycles after the data write. In that same cycle, status bit 0 (done flag) is set, and SCK then stays low.
- R6: IRQ is high exactly when the done flag is set and control bit 2 (interrupt enable) is set.
- R7: A data write during an active transfer is ignored. The byte in flight is unchanged and the transfer neither restarts nor lengthens.
- R8: The received byte, MSB first, reads back at address 2 once the transfer completes. It keeps its value until the next transfer completes.
- R9: Writing address 1 with bit 0 set clears the done flag. Writing it with bit 0 clear leaves the flag unchanged.
- R10: A data write while enable or master is clear starts nothing: SCK stays low, the flag stays clear and the read buffer is unchanged.
- R11: Clearing enable during a transfer aborts it. SCK is low by the second clock edge after the control write, and no done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The bench uses the default build: an 8-bit data width and dividers of 4, 16, 64 and 128. At the fastest divider a transfer takes only 32 cycles. That makes a full sweep of all 256 transmit bytes affordable, each paired with a receive byte computed from it, with SCK edges, timing, flag and interrupt checked on every transfer. The slower dividers are each covered by a single transfer, which exercises the rate decoding and the latched-rate counter up to its widest half period of 64. Ignored writes during a shift, writes without enable or master, and an abort while SCK is high are each driven at known cycle offsets.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      ADR_CTRL = 2'd0,
      ADR_STAT = 2'd1,
      ADR_DATA = 2'd2
   } reg_addr_e;

   // Control layout, LSB first: enable, master, irq_en, rate[1:0]
   typedef struct packed {
      logic [1:0] rate;
      logic       irq_en;
      logic       master;
      logic       enable;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
   import spi_bm_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   input  logic                  busy,
   input  logic                  done,
   input  logic [DATA_W-1:0]     rx_data,
   output ctrl_t                 ctrl,
   output logic                  start,
   output logic                  flag,
   output logic                  irq,
   output logic [DATA_W-1:0]     reg_rdata
);

   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("spi_bm_regs: DATA_W must hold the control fields");
   end

   logic wr_ctrl, wr_stat, wr_data;

   assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
   assign wr_stat = reg_wr && (reg_addr == ADR_STAT);
   assign wr_data = reg_wr && (reg_addr == ADR_DATA);

   // Single transmit buffer: a data write only counts when the shifter is idle
   assign start = wr_data && ctrl.enable && ctrl.master && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      end
   end

   // Completion wins over a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (done) begin
         flag <= 1'b1;
      end else if (wr_stat && reg_wdata[0]) begin
         flag <= 1'b0;
      end
   end

   assign irq = flag && ctrl.irq_en;

   always_comb begin
      unique case (reg_addr)
         ADR_CTRL: reg_rdata = DATA_W'(ctrl);
         ADR_STAT: reg_rdata = DATA_W'(flag);
         ADR_DATA: reg_rdata = rx_data;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/spi_bm_clkgen.sv
module spi_bm_clkgen #(
   parameter int unsigned R0_LOG2 = 2,
   parameter int unsigned R1_LOG2 = 4,
   parameter int unsigned R2_LOG2 = 6,
   parameter int unsigned R3_LOG2 = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       busy,
   input  logic       halt,
   input  logic [1:0] rate,
   output logic       sck,
   output logic       edge_rise,
   output logic       edge_fall
);

   localparam int unsigned MAX01   = (R0_LOG2 > R1_LOG2) ? R0_LOG2 : R1_LOG2;
   localparam int unsigned MAX23   = (R2_LOG2 > R3_LOG2) ? R2_LOG2 : R3_LOG2;
   localparam int unsigned MAX_LOG = (MAX01 > MAX23) ? MAX01 : MAX23;
   localparam int unsigned CNT_W   = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;
   localparam int unsigned N_RATES = 4;

   if (R0_LOG2 < 1 || R1_LOG2 < 1 || R2_LOG2 < 1 || R3_LOG2 < 1) begin : g_bad_rate
      $error("spi_bm_clkgen: every divider must be at least 2");
   end

   logic [CNT_W-1:0]   cnt;
   logic [1:0]         rate_q;
   logic [N_RATES-1:0] hit;
   logic               run;
   logic               term;

   // One half-period comparator per selectable divider
   for (genvar g = 0; g < N_RATES; g++) begin : g_rate
      localparam int unsigned LG =
         (g == 0) ? R0_LOG2 : (g == 1) ? R1_LOG2 : (g == 2) ? R2_LOG2 : R3_LOG2;
      localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (LG - 1)) - 1);
      assign hit[g] = (cnt == HALF_M1);
   end

   assign run       = busy && !halt;
   assign term      = run && hit[rate_q];
   assign edge_rise = term && !sck;
   assign edge_fall = term && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (start) begin
         rate_q <= rate;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (term) begin
         cnt <= '0;
         sck <= !sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              halt,
   input  logic [DATA_W-1:0] load_data,
   input  logic              edge_rise,
   input  logic              edge_fall,
   input  logic              miso,
   output logic              busy,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] rx_data
);

   localparam int unsigned BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [BC_W-1:0] LAST = BC_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_bm_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sh;
   logic [BC_W-1:0]   bcnt;
   logic              smp;
   logic [DATA_W-1:0] next_sh;

   assign next_sh = {sh[DATA_W-2:0], smp};
   assign done    = busy && !halt && edge_fall && (bcnt == LAST);
   assign mosi    = busy ? sh[DATA_W-1] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '0;
         bcnt <= '0;
         smp  <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         sh   <= load_data;
         bcnt <= '0;
      end else if (busy && halt) begin
         busy <= 1'b0;
         bcnt <= '0;
      end else if (busy) begin
         if (edge_rise) begin
            smp <= miso;
         end
         if (edge_fall) begin
            sh   <= next_sh;
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST) begin
               busy <= 1'b0;
            end
         end
      end
   end

   // Receive second stage: loaded only when a full byte completes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
      end else if (done) begin
         rx_data <= next_sh;
      end
   end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_bm_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned R0_LOG2 = 2,
   parameter int unsigned R1_LOG2 = 4,
   parameter int unsigned R2_LOG2 = 6,
   parameter int unsigned R3_LOG2 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              irq
);

   ctrl_t             ctrl;
   logic              start;
   logic              flag;
   logic              busy;
   logic              done;
   logic              halt;
   logic              edge_rise;
   logic              edge_fall;
   logic [DATA_W-1:0] rx_data;

   assign halt = !ctrl.enable;

   spi_bm_regs #(.DATA_W(DATA_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .done      (done),
      .rx_data   (rx_data),
      .ctrl      (ctrl),
      .start     (start),
      .flag      (flag),
      .irq       (irq),
      .reg_rdata (reg_rdata)
   );

   spi_bm_clkgen #(
      .R0_LOG2 (R0_LOG2),
      .R1_LOG2 (R1_LOG2),
      .R2_LOG2 (R2_LOG2),
      .R3_LOG2 (R3_LOG2)
   ) clkgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy),
      .halt      (halt),
      .rate      (ctrl.rate),
      .sck       (sck),
      .edge_rise (edge_rise),
      .edge_fall (edge_fall)
   );

   spi_bm_shifter #(.DATA_W(DATA_W)) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .halt      (halt),
      .load_data (reg_wdata),
      .edge_rise (edge_rise),
      .edge_fall (edge_fall),
      .miso      (miso),
      .busy      (busy),
      .mosi      (mosi),
      .done      (done),
      .rx_data   (rx_data)
   );

endmodule

// File: rtl/spi_bm_chk.sv
module spi_bm_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck,
   input logic              mosi,
   input logic              busy,
   input logic              flag,
   input logic [DATA_W-1:0] rx_data
);

   // R2: the serial clock rests low outside a transfer
   p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R5: the done flag rises on the cycle of a falling SCK edge
   p_flag_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(sck) && !sck));

   // R4, R7: within a transfer MOSI moves only on a falling SCK edge
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !($past(sck) && !sck)) |-> $stable(mosi));

   // R8: the read buffer changes only when a transfer ends on a falling edge
   p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> ($past(busy) && !busy && $past(sck) && !sck));

endmodule

bind spi_byte_master spi_bm_chk #(.DATA_W(DATA_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sck     (sck),
   .mosi    (mosi),
   .busy    (busy),
   .flag    (flag),
   .rx_data (rx_data)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       sck, mosi, irq;
   logic       miso = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_byte_master dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sck       (sck),
      .mosi      (mosi),
      .miso      (miso),
      .irq       (irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic int div_of(input int r);
      case (r)
         0: return 4;
         1: return 16;
         2: return 64;
         default: return 128;
      endcase
   endfunction

   // One transfer; inj >= 0 issues a conflicting data write at that sample
   task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int rate,
                       input bit ie, input int inj);
      int n = div_of(rate);
      int rises = 0, falls = 0, hi = 0, first = -1, late = 0;
      logic [7:0] cap = 8'd0;
      logic [7:0] v;
      logic prev = 1'b0;
      wr(2'd0, {3'b000, rate[1:0], ie, 1'b1, 1'b1});
      wr(2'd1, 8'h01);
      miso = slv[7];
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = tx;
      @(negedge clk);
      reg_wr = 1'b0;
      for (int k = 0; k < 8 * n; k++) begin
         if (k == inj) begin
            reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = ~tx;
         end else begin
            reg_wr = 1'b0;
         end
         if (sck && !prev) begin
            rises++;
            cap = {cap[6:0], mosi};
            if (first < 0) first = k;
         end
         if (sck) hi++;
         if (!sck && prev) begin
            falls++;
            if (falls < 8) miso = slv[7 - falls];
         end
         prev = sck;
         @(negedge clk);
      end
      reg_wr = 1'b0;
      chk(rises == 8, "R2 rising edge count", rises, 8);
      chk(hi == 4 * n, "R2 total high cycles", hi, 4 * n);
      chk(first == n / 2, "R3 first rise offset", first, n / 2);
      chk(cap == tx, "R4 mosi byte", cap, tx);
      chk(sck == 1'b0, "R5 sck low at end", sck, 0);
      rd(2'd1, v);
      chk(v == 8'h01, "R5 done flag", v, 1);
      chk(irq == ie, "R6 irq follows enable", irq, ie);
      rd(2'd2, v);
      chk(v == slv, "R8 received byte", v, slv);
      for (int k = 0; k < 2 * n; k++) begin
         if (sck) late++;
         @(negedge clk);
      end
      chk(late == 0, (inj >= 0) ? "R7 no restart after ignored write" : "R5 sck stays low",
          late, 0);
   endtask

   initial begin
      logic [7:0] v, keep;
      int hi_cnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sck == 1'b0, "R1 sck", sck, 0);
      chk(mosi == 1'b0, "R1 mosi", mosi, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
      rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
      rd(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 every divider
      for (int r = 0; r < 4; r++) xfer(8'hA5 ^ 8'(r), 8'h3C + 8'(r), r, r[0], -1);

      // R4 R8 exhaustive byte sweep at the fastest divider
      for (int t = 0; t < 256; t++) xfer(8'(t), {t[3:0], t[7:4]} ^ 8'h96, 0, t[1], -1);

      // R7 writes during a shift are dropped
      xfer(8'hC3, 8'h5A, 1, 1'b0, 20);
      xfer(8'h0F, 8'hF0, 2, 1'b1, 100);

      // R9 write-one-to-clear on status bit 0
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk(v == 8'h01, "R9 zero write keeps flag", v, 1);
      chk(irq == 1'b1, "R6 irq while flag set", irq, 1);
      wr(2'd1, 8'h01);
      rd(2'd1, v); chk(v == 8'h00, "R9 one write clears flag", v, 0);
      chk(irq == 1'b0, "R6 irq after clear", irq, 0);

      // R8 buffer holds while idle
      repeat (50) @(negedge clk);
      rd(2'd2, keep); chk(keep == 8'hF0, "R8 buffer held", keep, 8'hF0);

      // R10 no start without master, then without enable
      for (int m = 0; m < 2; m++) begin
         wr(2'd0, (m == 0) ? 8'h01 : 8'h02);
         wr(2'd2, 8'h99);
         hi_cnt = 0;
         for (int k = 0; k < 64; k++) begin
            if (sck) hi_cnt++;
            @(negedge clk);
         end
         chk(hi_cnt == 0, "R10 sck idle", hi_cnt, 0);
         rd(2'd1, v); chk(v == 8'h00, "R10 flag clear", v, 0);
         rd(2'd2, v); chk(v == keep, "R10 buffer unchanged", v, keep);
      end

      // R11 abort while SCK is high
      wr(2'd0, 8'h03);
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'hE7;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (2) @(negedge clk);
      chk(sck == 1'b1, "R11 sck high before abort", sck, 1);
      wr(2'd0, 8'h02);
      @(negedge clk);
      chk(sck == 1'b0, "R11 sck low after abort", sck, 0);
      hi_cnt = 0;
      for (int k = 0; k < 40; k++) begin
         if (sck) hi_cnt++;
         @(negedge clk);
      end
      chk(hi_cnt == 0, "R11 sck stays low", hi_cnt, 0);
      chk(mosi == 1'b0, "R11 mosi idle", mosi, 0);
      rd(2'd1, v); chk(v == 8'h00, "R11 no flag", v, 0);
      rd(2'd2, v); chk(v == keep, "R11 buffer unchanged", v, keep);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule